// File: doc/BRIEF.md
# Speed-Input Low-Power Entry Detector

This block watches the digital speed-command input of a motor controller and decides when the controller should drop into a low-power state and when it should come back out. The input has to stay low for a programmable number of microsecond ticks before entry is declared. A mode bit then chooses whether entry means standby or sleep.

Standby ends only when the commanded duty, given in steps of 0.1 %, is strictly greater than a programmable hysteresis margin. Sleep ends only on a rising edge of the speed input, and that edge also produces a one-cycle wake pulse. The window lengths are parameters that default to 50 µs, 200 µs, 20 ms and 200 ms. A free-running 1 µs tick from the surrounding chip supplies the time base.

Top module: `lp_entry_detect`

## Requirements
- R1: While reset is asserted, and right after it is released, `standby_o`, `sleep_o` and `wake_o` are all low.
- R2: `win_sel` picks the low-time window: 0 gives WIN0_US (default 50), 1 gives WIN1_US (default 200), 2 gives WIN2_US (default 20000) and 3 gives WIN3_US (default 200000) ticks. A low-power flag rises on the clock edge that samples the Nth consecutive tick with `spd_in` low, where N is the window length.
- R3: Only cycles with `us_tick` high advance the low-time count. Cycles without a tick never cause entry.
- R4: When the window completes, `lp_mode` = 0 raises `standby_o` and `lp_mode` = 1 raises `sleep_o`. The two flags are never high together.
- R5: Any clock edge that samples `spd_in` high while neither flag is set clears the low-time count to zero and prevents entry on that edge.
- R6: A change of `win_sel` or `lp_mode` while the window is being counted clears the count on the edge that first sees the new value. That edge does not count as a tick.
- R7: Standby is left on the edge that samples `duty_cmd` greater than `hyst_sel` × 20 (in 0.1 % units: 0, 2, 4 or 6 %). A duty equal to the threshold keeps standby.
- R8: While in standby, the speed input has no effect on the flags.
- R9: Sleep is left on the edge that samples `spd_in` high after a sampled low. On that same edge `wake_o` goes high for exactly one cycle, and `sleep_o` clears.
- R10: While in sleep, `duty_cmd` has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| spd_in | input | 1 | Digital speed-command input, already synchronised |
| duty_cmd | input | 10 | Commanded duty in 0.1 % units |
| win_sel | input | 2 | Low-time window select |
| lp_mode | input | 1 | Entry target: 0 = standby, 1 = sleep |
| hyst_sel | input | 2 | Standby exit margin select, 2 % per step |
| standby_o | output | 1 | Standby state flag |
| sleep_o | output | 1 | Sleep state flag |
| wake_o | output | 1 | One-cycle pulse when sleep is left |

## Verification
Entry is due on the edge that samples the last low tick of the window. The bench therefore steps the window length minus one edges checking that no flag is set, and then checks for the flag after the next edge. Standby exit and sleep exit, including the wake pulse, are due one edge after the duty or speed input changes. Every input is driven on the falling clock edge and every output is read at a falling edge after the rising edge where the result is due. A configuration change costs exactly one edge before counting resumes, and the restart checks count that edge in.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STBY = 2'd1,
        ST_SLP  = 2'd2
    } lp_state_e;

    typedef struct packed {
        lp_state_e  state;
        logic       pin;
        logic [2:0] cfg;
        logic       wake;
    } lp_regs_t;

endpackage

// File: rtl/lp_window_sel.sv
module lp_window_sel #(
    parameter int W0    = 50,
    parameter int W1    = 200,
    parameter int W2    = 20000,
    parameter int W3    = 200000,
    parameter int CNT_W = 18
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] limit
);
    localparam int NWIN = 4;
    localparam int WTAB [NWIN] = '{W0, W1, W2, W3};

    logic [CNT_W-1:0] lim_tab [NWIN];

    for (genvar i = 0; i < NWIN; i++) begin : g_lim
        assign lim_tab[i] = CNT_W'(WTAB[i]);
    end

    assign limit = lim_tab[sel];
endmodule

// File: rtl/lp_lowtime_ctr.sv
module lp_lowtime_ctr #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        reached = !clear && tick && (cnt_inc >= {1'b0, limit});
        cnt_d   = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = reached ? '0 : cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lp_hyst_cmp.sv
module lp_hyst_cmp #(
    parameter int DUTY_W    = 10,
    parameter int HYST_STEP = 20
) (
    input  logic [DUTY_W-1:0] duty,
    input  logic [1:0]        sel,
    output logic              above
);
    localparam int TW = DUTY_W + 1;

    logic [TW-1:0] thr;

    always_comb begin
        thr   = TW'(sel) * TW'(HYST_STEP);
        above = {1'b0, duty} > thr;
    end
endmodule

// File: rtl/lp_entry_detect.sv
module lp_entry_detect
    import lp_pkg::*;
#(
    parameter int WIN0_US   = 50,
    parameter int WIN1_US   = 200,
    parameter int WIN2_US   = 20000,
    parameter int WIN3_US   = 200000,
    parameter int DUTY_W    = 10,
    parameter int HYST_STEP = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              spd_in,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic [1:0]        win_sel,
    input  logic              lp_mode,
    input  logic [1:0]        hyst_sel,
    output logic              standby_o,
    output logic              sleep_o,
    output logic              wake_o
);
    localparam int WMAX01 = (WIN0_US > WIN1_US) ? WIN0_US : WIN1_US;
    localparam int WMAX23 = (WIN2_US > WIN3_US) ? WIN2_US : WIN3_US;
    localparam int WMAX   = (WMAX01 > WMAX23) ? WMAX01 : WMAX23;
    localparam int CNT_W  = $clog2(WMAX + 1);

    lp_regs_t         r_d, r_q;
    logic [CNT_W-1:0] win_limit;
    logic             win_done;
    logic             cnt_clear;
    logic             duty_above;
    logic             pin_rise;
    logic             cfg_chg;

    lp_window_sel #(
        .W0(WIN0_US), .W1(WIN1_US), .W2(WIN2_US), .W3(WIN3_US), .CNT_W(CNT_W)
    ) u_win (
        .sel   (win_sel),
        .limit (win_limit)
    );

    lp_lowtime_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .tick    (us_tick),
        .limit   (win_limit),
        .reached (win_done)
    );

    lp_hyst_cmp #(.DUTY_W(DUTY_W), .HYST_STEP(HYST_STEP)) u_hyst (
        .duty  (duty_cmd),
        .sel   (hyst_sel),
        .above (duty_above)
    );

    always_comb begin
        pin_rise  = spd_in && !r_q.pin;
        cfg_chg   = ({win_sel, lp_mode} != r_q.cfg);
        cnt_clear = (r_q.state != ST_RUN) || spd_in || cfg_chg;

        r_d       = r_q;
        r_d.pin   = spd_in;
        r_d.cfg   = {win_sel, lp_mode};
        r_d.wake  = 1'b0;

        case (r_q.state)
            ST_RUN: begin
                if (win_done) begin
                    r_d.state = lp_mode ? ST_SLP : ST_STBY;
                end
            end
            ST_STBY: begin
                if (duty_above) begin
                    r_d.state = ST_RUN;
                end
            end
            ST_SLP: begin
                if (pin_rise) begin
                    r_d.state = ST_RUN;
                    r_d.wake  = 1'b1;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, pin: 1'b0, cfg: 3'b000, wake: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign standby_o = (r_q.state == ST_STBY);
    assign sleep_o   = (r_q.state == ST_SLP);
    assign wake_o    = r_q.wake;
endmodule

// File: rtl/lp_entry_chk.sv
module lp_entry_chk #(
    parameter int DUTY_W    = 10,
    parameter int HYST_STEP = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              spd_in,
    input logic [DUTY_W-1:0] duty_cmd,
    input logic [1:0]        hyst_sel,
    input logic              standby_o,
    input logic              sleep_o,
    input logic              wake_o
);
    logic idle;
    assign idle = !standby_o && !sleep_o;

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!standby_o && !sleep_o && !wake_o);
        end
    end

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(standby_o && sleep_o));

    a_r3_no_tick_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !us_tick) |=> idle);

    a_r5_high_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && spd_in) |=> idle);

    a_r7_stby_exit_margin: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby_o) |-> ({1'b0, $past(duty_cmd)} > ((DUTY_W + 1)'($past(hyst_sel)) * (DUTY_W + 1)'(HYST_STEP))));

    a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    a_r9_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(sleep_o) && !sleep_o && $past(spd_in)));

    a_r9_sleep_exit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> wake_o);
endmodule

bind lp_entry_detect lp_entry_chk #(.DUTY_W(DUTY_W), .HYST_STEP(HYST_STEP)) u_chk (.*);

// File: tb/tb_lp_entry_detect.sv
`timescale 1ns/1ps
module tb_lp_entry_detect;
    localparam int W3_TB = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       spd_in = 1'b1;
    logic [9:0] duty_cmd = '0;
    logic [1:0] win_sel = '0;
    logic       lp_mode = 1'b0;
    logic [1:0] hyst_sel = '0;
    logic       standby_o, sleep_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lp_entry_detect #(.WIN3_US(W3_TB)) dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .spd_in(spd_in),
        .duty_cmd(duty_cmd), .win_sel(win_sel), .lp_mode(lp_mode),
        .hyst_sel(hyst_sel), .standby_o(standby_o), .sleep_o(sleep_o),
        .wake_o(wake_o)
    );

    // vector: {win_sel[1:0], lp_mode, hyst_sel[1:0], window ticks[17:0]}
    localparam logic [22:0] VEC [6] = '{
        {2'd0, 1'b0, 2'd0, 18'd50},
        {2'd1, 1'b0, 2'd1, 18'd200},
        {2'd2, 1'b1, 2'd0, 18'd20000},
        {2'd3, 1'b0, 2'd3, 18'(W3_TB)},
        {2'd0, 1'b1, 2'd2, 18'd50},
        {2'd1, 1'b1, 2'd3, 18'd200}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {standby,sleep,wake} actual %b expected %b", req, act, exp);
        end
    endtask

    // pin low for n ticks: quiet for n-1 edges, flags per mode at edge n
    task automatic run_win(input string req, input int n, input logic mode);
        logic early;
        early = 1'b0;
        spd_in = 1'b0;
        for (int i = 0; i < n - 1; i++) begin
            step();
            if (standby_o || sleep_o) early = 1'b1;
        end
        chk({req, " early"}, {early, 2'b00}, 3'b000);
        step();
        chk(req, {standby_o, sleep_o, wake_o}, mode ? 3'b010 : 3'b100);
    endtask

    initial begin
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1 in reset", {standby_o, sleep_o, wake_o}, 3'b000);
        step();
        rst_n = 1'b1;
        step();
        chk("R1 after reset", {standby_o, sleep_o, wake_o}, 3'b000);

        foreach (VEC[v]) begin
            logic [10:0] thr;
            spd_in   = 1'b1;
            duty_cmd = '0;
            win_sel  = VEC[v][22:21];
            lp_mode  = VEC[v][20];
            hyst_sel = VEC[v][19:18];
            thr      = 11'(hyst_sel) * 11'd20;
            step(); step();
            run_win(lp_mode ? "R2 R4 sleep entry" : "R2 R4 standby entry",
                    int'(VEC[v][17:0]), lp_mode);
            if (!lp_mode) begin
                spd_in = 1'b1; step();
                spd_in = 1'b0; step();
                chk("R8 pin ignored in standby", {standby_o, sleep_o, wake_o}, 3'b100);
                spd_in = 1'b1;
                duty_cmd = thr[9:0]; step();
                chk("R7 duty at threshold holds", {standby_o, sleep_o, wake_o}, 3'b100);
                duty_cmd = thr[9:0] + 10'd1; step();
                chk("R7 duty above threshold exits", {standby_o, sleep_o, wake_o}, 3'b000);
            end else begin
                duty_cmd = 10'd1000; step();
                chk("R10 duty ignored in sleep", {standby_o, sleep_o, wake_o}, 3'b010);
                spd_in = 1'b1; step();
                chk("R9 rise exits with wake", {standby_o, sleep_o, wake_o}, 3'b001);
                step();
                chk("R9 wake lasts one cycle", {standby_o, sleep_o, wake_o}, 3'b000);
            end
        end

        // R3: no ticks, no progress
        spd_in = 1'b1; duty_cmd = '0; win_sel = 2'd0; lp_mode = 1'b0; hyst_sel = 2'd0;
        step(); step();
        spd_in = 1'b0; us_tick = 1'b0;
        repeat (300) step();
        chk("R3 no tick no entry", {standby_o, sleep_o, wake_o}, 3'b000);
        us_tick = 1'b1;
        run_win("R3 ticks resume", 50, 1'b0);
        spd_in = 1'b1; duty_cmd = 10'd1; step();
        chk("R7 hyst 0 exits at duty 1", {standby_o, sleep_o, wake_o}, 3'b000);

        // R5: high glitch restarts
        duty_cmd = '0;
        spd_in = 1'b0;
        repeat (40) step();
        spd_in = 1'b1; step();
        chk("R5 glitch no entry", {standby_o, sleep_o, wake_o}, 3'b000);
        run_win("R5 full window after glitch", 50, 1'b0);
        spd_in = 1'b1; duty_cmd = 10'd5; step();
        duty_cmd = '0;

        // R6: config change restarts; change edge itself does not count
        spd_in = 1'b0;
        repeat (40) step();
        lp_mode = 1'b1; step();
        chk("R6 change edge no entry", {standby_o, sleep_o, wake_o}, 3'b000);
        run_win("R6 full window after change", 50, 1'b1);
        spd_in = 1'b1; step();
        chk("R9 wake after R6", {standby_o, sleep_o, wake_o}, 3'b001);
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule